// File: doc/BRIEF.md
# Checksummed Variable-Length Packet Receiver

This block turns a slow, master-clocked serial bus into whole packets. The inputs are a bus clock line and a bus data line, both already synchronised to the system clock. A data bit is taken at each rising edge of the bus clock. The line is active-low, so a low level stands for a logic 1. Eight bits make one byte, most significant bit first. The block stays idle until an external gap detector sends a one-cycle `gap_found` pulse. That pulse marks the start of a frame, restarts the byte counter and clears every output field.

A frame begins with four header bytes: destination address, source address, primary command and secondary command. A checksum byte follows, equal to the 8-bit sum of the four header bytes. Two flag bits in the primary command decide what comes next:

- Bit 7 adds a group of four data bytes.
- Bit 6 adds a group of five data bytes, followed by a second checksum. That checksum is the 8-bit sum of the header and all data bytes; the first checksum is not part of it.

A terminator byte ends every frame. A clean frame raises `pkt_valid` for one cycle. A zero destination address, a bad checksum or a non-zero terminator raises `abort_req` for one cycle and sends the block back to idle, ready for the next gap. Commands are not interpreted here.

Top module: `chkpkt_rx`

## Requirements
- R1: While idle, the block ignores bus activity. Only a `gap_found` pulse starts reception. A `gap_found` pulse during a frame drops the partial frame and starts again at the first header byte.
- R2: A bit is sampled at a rising edge of `line_clk`, and the sampled level is inverted (line low = 1). Bytes are assembled most significant bit first, eight edges per byte.
- R3: A destination address of 0x00 in the first byte raises `abort_req` and returns the block to idle.
- R4: The fifth byte must equal (destination + source + primary command + secondary command) mod 256. On a mismatch the block raises `abort_req` and returns to idle.
- R5: When bit 7 of the primary command is 1, four data bytes follow the first checksum. They go to payload slots 0 to 3, where slot k occupies `payload[8k+7:8k]`.
- R6: When bit 6 of the primary command is 1, five data bytes go to slots 4 to 8. A second checksum follows them: the mod-256 sum of the four header bytes and all received data bytes. On a mismatch the block raises `abort_req`.
- R7: The terminator comes after the last data byte, or after the first checksum when there is no data. A terminator of 0x00 raises `pkt_valid`; any other value raises `abort_req`. In both cases the block returns to idle.
- R8: `pkt_valid` and `abort_req` are never high together, and each pulse lasts one cycle. `pkt_valid` rises 2 clock cycles after the cycle in which `line_clk` rises for the last terminator bit.
- R9: `gap_found` clears the header fields and all payload slots to zero. Slots that the frame does not fill stay zero. All fields then hold their value until the next `gap_found`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_clk | input | 1 | Synchronised bus clock |
| line_dat | input | 1 | Synchronised bus data, active low |
| gap_found | input | 1 | One-cycle pulse that starts a frame |
| rx_addr | output | 8 | Destination address byte |
| tx_addr | output | 8 | Source address byte |
| cmd_a | output | 8 | Primary command byte (carries the flags) |
| cmd_b | output | 8 | Secondary command byte |
| payload | output | 72 | Nine data slots; slot k at bits 8k+7:8k |
| pkt_valid | output | 1 | One-cycle strobe for an accepted packet |
| abort_req | output | 1 | One-cycle strobe asking for a return to gap hunting |

## Verification
Each byte passes through two registers before the framer acts on it. The bit collector latches the eighth bit at the first clock edge that sees the bus clock high, and the framer registers its verdict on the next edge. `pkt_valid` or `abort_req` is therefore due exactly two cycles after the bench raises the bus clock for the final bit. The bench records the cycle of that last rise and the cycle in which it sees the strobe at a falling clock edge, then checks that the difference is two. It counts strobes at every falling edge, so a pulse longer than one cycle shows up as an extra count. Fields and counts are compared only after several idle cycles, once nothing is left in flight.

// File: rtl/chkpkt_pkg.sv
package chkpkt_pkg;
  localparam int BYTE_W = 8;
  localparam int HDR_N  = 4;

  typedef enum logic [2:0] {
    FS_IDLE, FS_HDR, FS_SUM1, FS_DATA, FS_SUM2, FS_TERM
  } fstate_t;

  // modulo-256 accumulate used by both checksums
  function automatic logic [BYTE_W-1:0] add_mod(input logic [BYTE_W-1:0] a,
                                                input logic [BYTE_W-1:0] b);
    logic [BYTE_W:0] t;
    t = {1'b0, a} + {1'b0, b};
    return t[BYTE_W-1:0];
  endfunction

  // line level to logic bit (bus is active low)
  function automatic logic line_to_bit(input logic lvl);
    return ~lvl;
  endfunction
endpackage

// File: rtl/chkpkt_bitcol.sv
module chkpkt_bitcol #(
  parameter int BITS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            restart,
  input  logic            enable,
  input  logic            line_clk,
  input  logic            line_dat,
  output logic            byte_stb,
  output logic [BITS-1:0] byte_q
);
  import chkpkt_pkg::*;
  localparam int CW = $clog2(BITS);
  localparam logic [CW-1:0] LAST = CW'(BITS - 1);

  logic            clk_d;
  logic [CW-1:0]   cnt;
  logic [BITS-1:0] shreg;
  logic            rise;
  logic [BITS-1:0] shifted;

  assign rise    = line_clk & ~clk_d;
  assign shifted = {shreg[BITS-2:0], line_to_bit(line_dat)};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      clk_d    <= 1'b0;
      cnt      <= '0;
      shreg    <= '0;
      byte_stb <= 1'b0;
      byte_q   <= '0;
    end else begin
      clk_d    <= line_clk;
      byte_stb <= 1'b0;
      if (restart) begin
        cnt   <= '0;
        shreg <= '0;
      end else if (enable && rise) begin
        shreg <= shifted;
        if (cnt == LAST) begin
          cnt      <= '0;
          byte_stb <= 1'b1;
          byte_q   <= shifted;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  // a byte needs eight edges, each spanning at least two cycles
  AST_BYTE_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    byte_stb |=> !byte_stb); // R2
endmodule

// File: rtl/chkpkt_sum.sv
module chkpkt_sum #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         add_en,
  input  logic [W-1:0] din,
  output logic [W-1:0] sum_q
);
  import chkpkt_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n)      sum_q <= '0;
    else if (clr)    sum_q <= '0;
    else if (add_en) sum_q <= add_mod(sum_q, din);
  end
endmodule

// File: rtl/chkpkt_framer.sv
module chkpkt_framer #(
  parameter int N_A    = 4,
  parameter int N_B    = 5,
  parameter int FLAG_A = 7,
  parameter int FLAG_B = 6
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   gap_found,
  input  logic                                   byte_stb,
  input  logic [chkpkt_pkg::BYTE_W-1:0]          byte_q,
  input  logic [chkpkt_pkg::BYTE_W-1:0]          sum_q,
  output logic                                   add_en,
  output logic                                   busy,
  output logic [chkpkt_pkg::HDR_N*chkpkt_pkg::BYTE_W-1:0] hdr_flat,
  output logic [(N_A+N_B)*chkpkt_pkg::BYTE_W-1:0] payload,
  output logic                                   pkt_valid,
  output logic                                   abort_req
);
  import chkpkt_pkg::*;
  localparam int NSLOT = N_A + N_B;
  localparam int IW    = $clog2(NSLOT + HDR_N);
  localparam logic [IW-1:0] HDR_LAST = IW'(HDR_N - 1);
  localparam logic [IW-1:0] A_LAST   = IW'(N_A - 1);
  localparam logic [IW-1:0] B_FIRST  = IW'(N_A);
  localparam logic [IW-1:0] B_LAST   = IW'(NSLOT - 1);
  localparam int CMD_POS = 2; // primary command is the third header byte

  fstate_t st;
  logic [IW-1:0] idx;
  logic [HDR_N-1:0][BYTE_W-1:0] hdr;
  logic [NSLOT-1:0][BYTE_W-1:0] slot;
  logic flag_a, flag_b, sum_ok;

  assign flag_a   = hdr[CMD_POS][FLAG_A];
  assign flag_b   = hdr[CMD_POS][FLAG_B];
  assign sum_ok   = (byte_q == sum_q);
  assign busy     = (st != FS_IDLE);
  assign add_en   = byte_stb && !gap_found && (st == FS_HDR || st == FS_DATA);
  assign hdr_flat = hdr;
  assign payload  = slot;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= FS_IDLE;
      idx       <= '0;
      hdr       <= '0;
      slot      <= '0;
      pkt_valid <= 1'b0;
      abort_req <= 1'b0;
    end else begin
      pkt_valid <= 1'b0;
      abort_req <= 1'b0;
      if (gap_found) begin
        st   <= FS_HDR;
        idx  <= '0;
        hdr  <= '0;
        slot <= '0;
      end else if (byte_stb) begin
        case (st)
          FS_HDR: begin
            hdr[idx[$clog2(HDR_N)-1:0]] <= byte_q;
            if (idx == '0 && byte_q == '0) begin
              abort_req <= 1'b1;
              st        <= FS_IDLE;
            end else if (idx == HDR_LAST) begin
              st <= FS_SUM1;
            end else begin
              idx <= idx + 1'b1;
            end
          end
          FS_SUM1: begin
            if (!sum_ok) begin
              abort_req <= 1'b1;
              st        <= FS_IDLE;
            end else if (flag_a) begin
              st  <= FS_DATA;
              idx <= '0;
            end else if (flag_b) begin
              st  <= FS_DATA;
              idx <= B_FIRST;
            end else begin
              st <= FS_TERM;
            end
          end
          FS_DATA: begin
            slot[idx] <= byte_q;
            if (idx == A_LAST && !flag_b) st <= FS_TERM;
            else if (idx == B_LAST)       st <= FS_SUM2;
            else                          idx <= idx + 1'b1;
          end
          FS_SUM2: begin
            if (!sum_ok) begin
              abort_req <= 1'b1;
              st        <= FS_IDLE;
            end else begin
              st <= FS_TERM;
            end
          end
          FS_TERM: begin
            if (byte_q == '0) pkt_valid <= 1'b1;
            else              abort_req <= 1'b1;
            st <= FS_IDLE;
          end
          default: st <= FS_IDLE;
        endcase
      end
    end
  end

  AST_STROBES_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(pkt_valid && abort_req)); // R8
  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid |=> !pkt_valid); // R8
  AST_END_IS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid || abort_req) |-> (st == FS_IDLE)); // R7
  AST_ZERO_DEST: assert property (@(posedge clk) disable iff (!rst_n)
    (st == FS_HDR && idx == '0 && byte_stb && !gap_found && byte_q == '0) |=> abort_req); // R3
  AST_SUM1_BAD: assert property (@(posedge clk) disable iff (!rst_n)
    (st == FS_SUM1 && byte_stb && !gap_found && !sum_ok) |=> abort_req); // R4
  AST_SUM2_BAD: assert property (@(posedge clk) disable iff (!rst_n)
    (st == FS_SUM2 && byte_stb && !gap_found && !sum_ok) |=> abort_req); // R6
  AST_FIELDS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (st == FS_IDLE && !gap_found) |=> ($stable(hdr_flat) && $stable(payload))); // R9
endmodule

// File: rtl/chkpkt_rx.sv
module chkpkt_rx #(
  parameter int N_A    = 4,
  parameter int N_B    = 5,
  parameter int FLAG_A = 7,
  parameter int FLAG_B = 6
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      line_clk,
  input  logic                      line_dat,
  input  logic                      gap_found,
  output logic [7:0]                rx_addr,
  output logic [7:0]                tx_addr,
  output logic [7:0]                cmd_a,
  output logic [7:0]                cmd_b,
  output logic [(N_A+N_B)*8-1:0]    payload,
  output logic                      pkt_valid,
  output logic                      abort_req
);
  import chkpkt_pkg::*;

  logic              byte_stb, add_en, busy;
  logic [BYTE_W-1:0] byte_q, sum_q;
  logic [HDR_N*BYTE_W-1:0] hdr_flat;

  chkpkt_bitcol #(.BITS(BYTE_W)) u_bits (
    .clk(clk), .rst_n(rst_n), .restart(gap_found), .enable(busy),
    .line_clk(line_clk), .line_dat(line_dat),
    .byte_stb(byte_stb), .byte_q(byte_q));

  chkpkt_sum #(.W(BYTE_W)) u_sum (
    .clk(clk), .rst_n(rst_n), .clr(gap_found), .add_en(add_en),
    .din(byte_q), .sum_q(sum_q));

  chkpkt_framer #(.N_A(N_A), .N_B(N_B), .FLAG_A(FLAG_A), .FLAG_B(FLAG_B)) u_frm (
    .clk(clk), .rst_n(rst_n), .gap_found(gap_found),
    .byte_stb(byte_stb), .byte_q(byte_q), .sum_q(sum_q),
    .add_en(add_en), .busy(busy), .hdr_flat(hdr_flat), .payload(payload),
    .pkt_valid(pkt_valid), .abort_req(abort_req));

  assign rx_addr = hdr_flat[7:0];
  assign tx_addr = hdr_flat[15:8];
  assign cmd_a   = hdr_flat[23:16];
  assign cmd_b   = hdr_flat[31:24];
endmodule

// File: tb/chkpkt_rx_test.sv
module chkpkt_rx_test;
  logic clk = 0, rst_n = 0, line_clk = 0, line_dat = 1, gap_found = 0;
  logic [7:0] rx_addr, tx_addr, cmd_a, cmd_b;
  logic [71:0] payload;
  logic pkt_valid, abort_req;
  int checks = 0, errors = 0, cyc = 0, nvalid = 0, nabort = 0;
  int rise_cyc = 0, vld_cyc = 0;

  always #5 clk = ~clk;

  chkpkt_rx uut (.clk(clk), .rst_n(rst_n), .line_clk(line_clk), .line_dat(line_dat),
    .gap_found(gap_found), .rx_addr(rx_addr), .tx_addr(tx_addr), .cmd_a(cmd_a),
    .cmd_b(cmd_b), .payload(payload), .pkt_valid(pkt_valid), .abort_req(abort_req));

  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) begin
    if (pkt_valid) begin nvalid++; vld_cyc = cyc; end
    if (abort_req) nabort++;
  end

  // vector: rx tx c1 c2 | d0..d8 | corrupt(1=sum1,2=sum2) | term | expect(0 valid,1 abort)
  localparam int NV = 8;
  localparam logic [115:0] VECS [NV] = '{
    {8'h30, 8'h10, 8'h01, 8'h12, 72'h0, 2'd0, 8'h00, 2'd0},
    {8'h31, 8'h18, 8'h90, 8'h5C, 72'hA5_3C_0F_F0_00_00_00_00_00, 2'd0, 8'h00, 2'd0},
    {8'h42, 8'h18, 8'h40, 8'h07, 72'h00_00_00_00_81_7E_C3_19_66, 2'd0, 8'h00, 2'd0},
    {8'hFF, 8'h80, 8'hC5, 8'hEE, 72'h11_22_33_44_55_66_77_88_99, 2'd0, 8'h00, 2'd0},
    {8'h30, 8'h10, 8'h01, 8'h12, 72'h0, 2'd1, 8'h00, 2'd1},
    {8'h55, 8'hAA, 8'hC0, 8'h01, 72'h01_02_03_04_05_06_07_08_09, 2'd2, 8'h00, 2'd1},
    {8'h30, 8'h10, 8'h20, 8'h00, 72'h0, 2'd0, 8'h5A, 2'd1},
    {8'h00, 8'h10, 8'h01, 8'h12, 72'h0, 2'd0, 8'h00, 2'd1}
  };

  task automatic check(input string req, input logic [127:0] got, input logic [127:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk); line_dat = ~b;
    repeat (2) @(negedge clk);
    line_clk = 1; rise_cyc = cyc;
    repeat (2) @(negedge clk);
    line_clk = 0;
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
  endtask

  task automatic pulse_gap;
    @(negedge clk); gap_found = 1;
    @(negedge clk); gap_found = 0;
  endtask

  function automatic logic [7:0] dbyte(input logic [115:0] v, input int k);
    return v[83 - 8*k -: 8];
  endfunction

  // builds the frame from the vector and returns the fields it should leave
  task automatic send_frame(input logic [115:0] v, output logic [103:0] fields);
    logic [7:0] s, c1;
    logic [71:0] pl;
    c1 = v[99:92];
    pl = '0;
    s = v[115:108] + v[107:100] + v[99:92] + v[91:84];
    send_byte(v[115:108]); send_byte(v[107:100]);
    send_byte(v[99:92]);   send_byte(v[91:84]);
    send_byte(v[11:10] == 2'd1 ? ~s : s);
    if (c1[7]) for (int k = 0; k < 4; k++) begin
      send_byte(dbyte(v, k)); s = s + dbyte(v, k); pl[8*k +: 8] = dbyte(v, k);
    end
    if (c1[6]) begin
      for (int k = 4; k < 9; k++) begin
        send_byte(dbyte(v, k)); s = s + dbyte(v, k); pl[8*k +: 8] = dbyte(v, k);
      end
      send_byte(v[11:10] == 2'd2 ? ~s : s);
    end
    send_byte(v[9:2]);
    fields = {v[115:108], v[107:100], v[99:92], v[91:84], pl};
  endtask

  function automatic logic [103:0] got_fields();
    return {rx_addr, tx_addr, cmd_a, cmd_b, payload};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [103:0] exp_f, first_f;
    int v0, a0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);
    // reset state (R9, R8)
    check("R9 reset fields", 128'(got_fields()), 128'(0));
    check("R8 reset strobes", 128'({pkt_valid, abort_req}), 128'(0));

    // table walk (R2..R8)
    for (int n = 0; n < NV; n++) begin
      v0 = nvalid; a0 = nabort;
      pulse_gap;
      send_frame(VECS[n], exp_f);
      repeat (4) @(negedge clk);
      if (VECS[n][1:0] == 2'd0) begin
        check("R7 R8 one valid pulse, no abort", 128'({nvalid - v0, nabort - a0}), 128'({32'd1, 32'd0}));
        check("R2 R5 R6 fields", 128'(got_fields()), 128'(exp_f));
        check("R8 valid latency", 128'(vld_cyc - rise_cyc), 128'(2));
      end else begin
        check("R3 R4 R6 R7 one abort pulse, no valid", 128'({nvalid - v0, nabort - a0}), 128'({32'd0, 32'd1}));
      end
    end

    // R9: fields hold with no gap, then gap clears them
    pulse_gap;
    send_frame(VECS[3], first_f);
    repeat (4) @(negedge clk);
    v0 = nvalid; a0 = nabort;
    send_byte(8'h5A); send_byte(8'h00);
    repeat (4) @(negedge clk);
    check("R9 fields hold while idle", 128'(got_fields()), 128'(first_f));
    check("R1 idle bits ignored", 128'({nvalid - v0, nabort - a0}), 128'(0));
    pulse_gap;
    @(negedge clk);
    check("R9 gap clears fields", 128'(got_fields()), 128'(0));

    // R1: gap mid-frame restarts reception
    v0 = nvalid; a0 = nabort;
    send_byte(8'h77); send_byte(8'h66); send_byte(8'h81);
    pulse_gap;
    send_frame(VECS[1], exp_f);
    repeat (4) @(negedge clk);
    check("R1 restart gives one valid", 128'({nvalid - v0, nabort - a0}), 128'({32'd1, 32'd0}));
    check("R1 restart fields from new frame", 128'(got_fields()), 128'(exp_f));

    // R1: full frame without any gap is ignored after an ended frame
    v0 = nvalid; a0 = nabort;
    send_frame(VECS[0], exp_f);
    repeat (4) @(negedge clk);
    check("R1 frame without gap ignored", 128'({nvalid - v0, nabort - a0}), 128'(0));

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule